// File: doc/BRIEF.md
# Serial Shift-Register Output Driver

This block takes a parallel word of output levels, for example PWM or GPIO states, and shifts it out to an external chain of serial-in parallel-out shift registers. It drives three lines: serial data, a serial clock and an optional latch strobe. The serial clock is made from the bus clock through one of four divisors. A programmable delay decides how far into the low phase of the serial clock the data line moves. The receiving chip samples data on the rising edge.

Two kinds of receiving chip are supported. The first has an output latch and needs a strobe after the last bit before its outputs change. The second has no latch, so its outputs follow the shift sequence directly. A mode input picks one or the other.

The block accepts a transfer on a one-cycle start pulse while idle. It captures the word and the whole configuration at that moment, then reports busy until the transfer ends. A single-cycle done pulse marks the end.

Top module: `sipo_out_driver`

## Requirements
- R1: The divisor select picks the serial clock divisor as follows: 2'b00 gives 32 (the zero default), 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 16. The high phase and the low phase of every serial clock pulse each last exactly divisor/2 bus clocks.
- R2: The delay input counts bus clocks from 1 to 16, and a value of 0 is treated as 1. The data line takes a new bit in low-phase cycle number `delay` (counting the first low cycle as 1).
- R3: A delay larger than divisor/2 is clamped to divisor/2, so the data line never changes in a later cycle than the last low cycle.
- R4: Bits leave most significant bit first. Each bit is on the data line during the whole high phase of its serial clock pulse, and exactly NBITS pulses are produced per transfer.
- R5: When latch mode is 1, the latch strobe goes high right after the last high phase. It stays high for one full serial clock period (the divisor, in bus clocks) while the serial clock stays low.
- R6: When latch mode is 0, the latch strobe never goes high.
- R7: Done is a one-cycle pulse with busy low. It comes in the cycle after the last high phase (no-latch mode) or after the strobe falls (latch mode). The first done therefore appears NBITS*div+1 or NBITS*div+div+1 cycles after the start edge.
- R8: A start request made while busy is ignored. The running transfer is neither restarted nor extended, and no second transfer follows it.
- R9: During and after reset the serial clock, latch strobe, data line, busy and done are all low. The serial clock and latch strobe also stay low whenever the block is idle.
- R10: The word, divisor select, delay and mode are captured when a transfer is accepted. Changing these inputs during a transfer has no effect on it.
- R11: Busy goes high in the cycle after the accepted start edge and stays high until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start request, one cycle, accepted when idle |
| tx_word | input | NBITS | Parallel word to shift out |
| div_sel | input | 2 | Serial clock divisor select |
| clk_dly | input | DLY_W | Data-change delay in bus clocks |
| latch_mode | input | 1 | 1: chip with output latch, 0: chip without latch |
| sclk | output | 1 | Serial clock, idles low |
| sdata | output | 1 | Serial data |
| slatch | output | 1 | Latch strobe, idles low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
A start request can reach the block on the same edge on which the sequencer is stepping its counters or moving the data line. At that edge the block must neither recapture the configuration nor restart the shift. To provoke this, the bench pulses start in the 40th cycle of a running transfer. In the same cycle it flips the word, the divisor select, the delay and the mode. The result is judged on three things: the scoreboard's bit-by-bit stream and phase lengths, which were queued from the original settings; the total cycle count to done; and busy staying low after done.

// File: rtl/sipo_pkg.sv
// Package: shared constants, state type and divisor decode for the
// serial shift-register output driver. Assumes a maximum divisor of 32.
package sipo_pkg;

    localparam int unsigned DIV_W = 6;   // wide enough to hold 32

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOW   = 2'd1,
        ST_HIGH  = 2'd2,
        ST_LATCH = 2'd3
    } sipo_state_e;

    // Map the divisor select code to a divisor in bus clocks (zero code = 32).
    function automatic logic [DIV_W-1:0] div_of(input logic [1:0] sel);
        logic [DIV_W-1:0] r;
        case (sel)
            2'b01:   r = DIV_W'(4);
            2'b10:   r = DIV_W'(8);
            2'b11:   r = DIV_W'(16);
            default: r = DIV_W'(32);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sipo_timing_cfg.sv
// Timing configuration decode: turns the divisor select and the requested
// delay into a half-period length and an effective delay. A zero delay is
// treated as 1 and a delay above half the divisor is clamped to it.
// Purely combinational; the sequencer captures the results at start.
module sipo_timing_cfg
    import sipo_pkg::*;
#(
    parameter int unsigned DLY_W = 5
) (
    input  logic [1:0]       div_sel,
    input  logic [DLY_W-1:0] dly_req,
    output logic [DIV_W-1:0] half_len,
    output logic [DIV_W-1:0] eff_dly
);
    localparam int unsigned CW = (DLY_W > DIV_W) ? DLY_W : DIV_W;

    logic [DIV_W-1:0] div_full;
    logic [CW-1:0]    dly_ext;
    logic [CW-1:0]    half_ext;

    // Decode divisor, substitute the zero delay and clamp against half.
    always_comb begin
        div_full = div_of(div_sel);
        half_len = div_full >> 1;
        half_ext = CW'(half_len);
        dly_ext  = (dly_req == '0) ? CW'(1) : CW'(dly_req);
        eff_dly  = (dly_ext > half_ext) ? half_len : DIV_W'(dly_ext);
    end

endmodule

// File: rtl/sipo_shift_seq.sv
// Shift sequencer: on an accepted start it captures the word and timing,
// then for each bit (MSB first) runs a low phase and a high phase of
// half_q bus clocks each. The data line moves in low cycle number eff_q.
// An optional latch strobe follows for a full serial period. Assumes
// half_in >= 1 and 1 <= eff_in <= half_in.
module sipo_shift_seq
    import sipo_pkg::*;
#(
    parameter int unsigned NBITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NBITS-1:0] word_in,
    input  logic [DIV_W-1:0] half_in,
    input  logic [DIV_W-1:0] eff_in,
    input  logic             latch_in,
    output logic             sclk,
    output logic             sdata,
    output logic             slatch,
    output logic             busy,
    output logic             done,
    output logic [DIV_W-1:0] half_cap,
    output logic             lat_cap
);
    localparam int unsigned      IDX_W    = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBITS - 1);
    localparam logic [DIV_W-1:0] CNT_ONE  = DIV_W'(1);

    sipo_state_e      st_q, st_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [NBITS-1:0] word_q, word_now;
    logic [DIV_W-1:0] half_q, eff_q, eff_now, per_last;
    logic             lat_q;
    logic             sdata_q, done_q;
    logic             fin, load_bit, accept;

    // Next-state logic for phase, counter and bit index.
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        idx_d    = idx_q;
        fin      = 1'b0;
        accept   = 1'b0;
        per_last = (half_q << 1) - CNT_ONE;
        case (st_q)
            ST_IDLE: begin
                if (start) begin
                    accept = 1'b1;
                    st_d   = ST_LOW;
                    cnt_d  = '0;
                    idx_d  = IDX_LAST;
                end
            end
            ST_LOW: begin
                if (cnt_q == half_q - CNT_ONE) begin
                    st_d  = ST_HIGH;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            ST_HIGH: begin
                if (cnt_q == half_q - CNT_ONE) begin
                    cnt_d = '0;
                    if (idx_q == '0) begin
                        if (lat_q) begin
                            st_d = ST_LATCH;
                        end else begin
                            st_d = ST_IDLE;
                            fin  = 1'b1;
                        end
                    end else begin
                        idx_d = idx_q - IDX_W'(1);
                        st_d  = ST_LOW;
                    end
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            default: begin
                if (cnt_q == per_last) begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                    fin   = 1'b1;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
        endcase
    end

    // Choose word and delay source (inputs on the accepting edge) and decide on a bit load.
    always_comb begin
        word_now = accept ? word_in : word_q;
        eff_now  = accept ? eff_in  : eff_q;
        load_bit = (st_d == ST_LOW) && (cnt_d == eff_now - CNT_ONE);
    end

    // Sequencer registers, data line and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            word_q  <= '0;
            half_q  <= DIV_W'(16);
            eff_q   <= CNT_ONE;
            lat_q   <= 1'b0;
            sdata_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            idx_q  <= idx_d;
            done_q <= fin;
            if (accept) begin
                word_q <= word_in;
                half_q <= half_in;
                eff_q  <= eff_in;
                lat_q  <= latch_in;
            end
            if (load_bit) begin
                sdata_q <= word_now[idx_d];
            end
        end
    end

    // Output decode from the registered phase.
    always_comb begin
        sclk     = (st_q == ST_HIGH);
        slatch   = (st_q == ST_LATCH);
        busy     = (st_q != ST_IDLE);
        sdata    = sdata_q;
        done     = done_q;
        half_cap = half_q;
        lat_cap  = lat_q;
    end

endmodule

// File: rtl/sipo_out_driver.sv
// Top level of the serial shift-register output driver: timing decode
// followed by the shift sequencer. All outputs are registered or decoded
// from registered state. Synchronous active-low reset.
module sipo_out_driver
    import sipo_pkg::*;
#(
    parameter int unsigned NBITS = 16,
    parameter int unsigned DLY_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NBITS-1:0] tx_word,
    input  logic [1:0]       div_sel,
    input  logic [DLY_W-1:0] clk_dly,
    input  logic             latch_mode,
    output logic             sclk,
    output logic             sdata,
    output logic             slatch,
    output logic             busy,
    output logic             done
);
    logic [DIV_W-1:0] half_cfg;
    logic [DIV_W-1:0] eff_cfg;
    logic [DIV_W-1:0] half_cap;
    logic             lat_cap;

    sipo_timing_cfg #(.DLY_W(DLY_W)) u_cfg (
        .div_sel  (div_sel),
        .dly_req  (clk_dly),
        .half_len (half_cfg),
        .eff_dly  (eff_cfg)
    );

    sipo_shift_seq #(.NBITS(NBITS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .word_in  (tx_word),
        .half_in  (half_cfg),
        .eff_in   (eff_cfg),
        .latch_in (latch_mode),
        .sclk     (sclk),
        .sdata    (sdata),
        .slatch   (slatch),
        .busy     (busy),
        .done     (done),
        .half_cap (half_cap),
        .lat_cap  (lat_cap)
    );

endmodule

// File: rtl/sipo_out_driver_chk.sv
// Assertion checker for the serial shift-register output driver, attached
// to the top module by bind. Observes ports and the captured configuration.
module sipo_out_driver_chk
    import sipo_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             sclk,
    input logic             sdata,
    input logic             slatch,
    input logic             busy,
    input logic             done,
    input logic [DIV_W-1:0] half_cfg,
    input logic [DIV_W-1:0] eff_cfg,
    input logic [DIV_W-1:0] half_cap,
    input logic             lat_cap
);
    logic [DIV_W-1:0] hcnt;

    // Count consecutive high cycles of the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) hcnt <= '0;
        else        hcnt <= sclk ? hcnt + DIV_W'(1) : '0;
    end

    assert_high_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> hcnt == half_cap);

    assert_dly_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_cfg >= DIV_W'(1)) && (eff_cfg <= half_cfg));

    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata));

    assert_latch_clk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slatch |-> !sclk);

    assert_latch_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        slatch |-> lat_cap);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_keep_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> $stable(half_cap) && $stable(lat_cap));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !slatch));

    assert_low_continues_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sclk && !slatch) |=> busy);

endmodule

bind sipo_out_driver sipo_out_driver_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .sclk     (sclk),
    .sdata    (sdata),
    .slatch   (slatch),
    .busy     (busy),
    .done     (done),
    .half_cfg (half_cfg),
    .eff_cfg  (eff_cfg),
    .half_cap (half_cap),
    .lat_cap  (lat_cap)
);

// File: tb/sipo_out_driver_bench.sv
// Scoreboard bench: the driver task queues one expected item per bit; the
// monitor pops an item on each serial clock rise and checks bit, phase
// lengths and data-change position.
module sipo_out_driver_bench;
    localparam int NBITS = 16;
    localparam int DLY_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [NBITS-1:0] tx_word = '0;
    logic [1:0]       div_sel = 2'b00;
    logic [DLY_W-1:0] clk_dly = '0;
    logic             latch_mode = 1'b0;
    logic             sclk, sdata, slatch, busy, done;

    typedef struct {
        logic  b;
        int    half;
        int    eff;
        string rq;
    } item_t;

    item_t exp_q[$];
    item_t it;
    int    n_chk = 0;
    int    n_err = 0;
    int    lc = 0, chg = 0, hc = 0, lat_cnt = 0, last_half = 0;
    logic  psclk = 1'b0, psdata = 1'b0;

    always #10 clk = ~clk;

    sipo_out_driver #(.NBITS(NBITS), .DLY_W(DLY_W)) u_sipo_out_driver (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
        .div_sel(div_sel), .clk_dly(clk_dly), .latch_mode(latch_mode),
        .sclk(sclk), .sdata(sdata), .slatch(slatch), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Monitor: phase lengths, bit order and data-change position.
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !sclk) begin
                lc++;
                if (sdata !== psdata) chg = lc;
            end
            if (sclk && !psclk) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected pulse", 1, 0);
                end else begin
                    it = exp_q.pop_front();
                    check(sdata === it.b, "R4 bit value", int'(sdata), int'(it.b));
                    check(lc == it.half, "R1 low phase", lc, it.half);
                    if (chg != 0) check(chg == it.eff, {it.rq, " change cycle"}, chg, it.eff);
                    last_half = it.half;
                end
                lc = 0; chg = 0; hc = 1;
            end else if (sclk && psclk) begin
                hc++;
            end
            if (!sclk && psclk) check(hc == last_half, "R1 high phase", hc, last_half);
            if (slatch) lat_cnt++;
            if (!busy) begin lc = 0; chg = 0; end
            psclk  = sclk;
            psdata = sdata;
        end
    end

    // Driver: queue expectations, start a transfer, time it to done.
    task automatic run_xfer(input logic [NBITS-1:0] w, input logic [1:0] sel,
                            input logic [DLY_W-1:0] dly, input logic lm, input bit poke);
        int div, half, e, cycles, exp_cyc;
        item_t x;
        div  = (sel == 2'b01) ? 4 : (sel == 2'b10) ? 8 : (sel == 2'b11) ? 16 : 32;
        half = div / 2;
        e    = (dly == 0) ? 1 : int'(dly);
        x.rq = (e > half) ? "R3" : "R2";
        if (e > half) e = half;
        for (int i = NBITS - 1; i >= 0; i--) begin
            x.b = w[i]; x.half = half; x.eff = e;
            exp_q.push_back(x);
        end
        exp_cyc = NBITS * div + (lm ? div : 0) + 1;
        @(negedge clk);
        tx_word = w; div_sel = sel; clk_dly = dly; latch_mode = lm; start = 1'b1;
        lat_cnt = 0;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        check(busy === 1'b1, "R11 busy after start", int'(busy), 1);
        while (done !== 1'b1) begin
            @(negedge clk);
            cycles++;
            if (poke && cycles == 40) begin
                start = 1'b1; tx_word = ~w; div_sel = sel + 2'b01;
                clk_dly = dly + 5'd3; latch_mode = ~lm;
            end
            if (poke && cycles == 41) start = 1'b0;
            if (done !== 1'b1 && busy !== 1'b1) begin
                check(1'b0, "R11 busy dropped early", cycles, exp_cyc);
                break;
            end
        end
        check(cycles == exp_cyc, lm ? "R5 done timing" : "R6 done timing", cycles, exp_cyc);
        if (poke) check(cycles == exp_cyc, "R10 config held", cycles, exp_cyc);
        check(busy === 1'b0, "R7 busy low with done", int'(busy), 0);
        check(lat_cnt == (lm ? div : 0), lm ? "R5 strobe length" : "R6 no strobe",
              lat_cnt, lm ? div : 0);
        check(exp_q.size() == 0, "R4 pulse count", exp_q.size(), 0);
        @(negedge clk);
        check(done === 1'b0, "R7 done one cycle", int'(done), 0);
        if (poke) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                check(busy === 1'b0, "R8 ignored start", int'(busy), 0);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(sclk === 1'b0 && slatch === 1'b0 && sdata === 1'b0 &&
              busy === 1'b0 && done === 1'b0, "R9 reset state",
              int'({sclk, slatch, sdata, busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && sclk === 1'b0, "R9 idle after reset", int'({busy, sclk}), 0);
        run_xfer(16'hA5C3, 2'b00, 5'd0,  1'b1, 1'b0);  // default divisor, delay 0 -> 1
        run_xfer(16'h3C96, 2'b01, 5'd2,  1'b0, 1'b0);  // delay exactly half
        run_xfer(16'h5AF0, 2'b10, 5'd9,  1'b1, 1'b0);  // clamp 9 -> 4
        run_xfer(16'hC3A5, 2'b11, 5'd16, 1'b0, 1'b0);  // clamp 16 -> 8
        run_xfer(16'h9669, 2'b01, 5'd16, 1'b1, 1'b0);  // clamp 16 -> 2
        run_xfer(16'h0FF1, 2'b10, 5'd3,  1'b0, 1'b1);  // start and config change while busy
        run_xfer(16'hE718, 2'b11, 5'd5,  1'b1, 1'b0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule